// File: doc/BRIEF.md
# Multidrop TAP Address Selection Controller

This block lets one test bridge on a shared backplane scan bus decide whether the scan master is talking to it. It follows the standard IEEE 1149.1 TAP state machine from the backplane TCK, TMS and TDI inputs. On top of the TAP it keeps a selection state machine. While the device is unselected, the low bits of any value shifted into its instruction register are treated as an address. On Update-IR that address is compared with a static six-bit slot number, with the all-ones broadcast code, and with the multicast group code assigned to this device by a static two-bit input.

A unique match makes this the only talking device. Its backplane TDO driver is then enabled during Shift-IR and Shift-DR, and the scan path runs through the instruction register or a 32-bit identification register. A broadcast or multicast match selects many devices at once, so the TDO driver stays off for the whole time the device is selected that way. Any non-matching Update-IR, or Test-Logic-Reset, returns the block to the waiting state. The current selection kind is reported on a two-bit output.

Top module: `mts_top`

## Requirements
- R1: While TRST_n is low, and after it rises, the selection kind is none (code 0) and the TDO enable is low.
- R2: An Update-IR whose low six instruction bits equal the slot input selects the device as unique (kind code 1), provided the slot value lies in the unique range 0 to 58.
- R3: An Update-IR with an address that matches none of the device's codes leaves the kind at none (code 0), whether the device was waiting or already selected. The kind changes only on an Update-IR or in Test-Logic-Reset.
- R4: Address 6'h3F selects the device as broadcast (kind code 2), whatever the slot input holds.
- R5: Addresses 6'h3B to 6'h3E are multicast groups 0 to 3. Address 6'h3B plus the group input selects multicast (kind code 3). The other three group codes deselect the device.
- R6: Under broadcast, multicast or no selection, the TDO enable never goes high, in any TAP state.
- R7: Under unique selection, the TDO enable is high in Shift-IR and Shift-DR only. TDO and its enable change on the falling edge of TCK.
- R8: Capture-IR loads 8'h01 into the instruction register. Shift-IR presents it on TDO least significant bit first.
- R9: Capture-DR loads the 32-bit identification value (default 32'h4D2A6C35). Shift-DR presents it on TDO least significant bit first.
- R10: Five TCK cycles with TMS high reach Test-Logic-Reset, and the kind returns to none.
- R11: TRST_n going low deselects the device at once, without waiting for a TCK edge.
- R12: A slot value in the reserved range 59 to 63 is never matched as a unique address. Only its broadcast or group meaning applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Backplane mode select |
| tdi | input | 1 | Backplane serial data in |
| slot_id | input | 6 | Static device address |
| mcast_grp | input | 2 | Static multicast group membership |
| tdo | output | 1 | Backplane serial data out |
| tdo_oe | output | 1 | Tri-state enable for the TDO driver |
| sel_kind | output | 2 | 0 none, 1 unique, 2 broadcast, 3 multicast |

## Verification
Two events can land on one Update-IR edge: the device is dropped from its current selection and a new one is decoded. When it moves from unique to broadcast, the TDO enable rule also switches in the same step. The bench provokes this by scanning a broadcast address straight after a unique selection. It also scans random addresses while the device is already selected. It then judges that the next shift keeps TDO disabled and that the reported kind matches the value its own decoder function computes from the new address alone.

// File: rtl/mts_pkg.sv
package mts_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {
    SK_NONE   = 2'd0,
    SK_UNIQUE = 2'd1,
    SK_BCAST  = 2'd2,
    SK_MCAST  = 2'd3
  } sel_kind_e;

  function automatic tap_st_e tap_next(input tap_st_e st, input logic tms);
    tap_st_e nx;
    case (st)
      TS_RESET:  nx = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nx = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nx = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nx = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nx = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nx = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nx = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nx = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nx = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nx = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nx = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nx = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nx = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nx = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nx = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nx = tms ? TS_SEL_DR : TS_IDLE;
      default:   nx = TS_RESET;
    endcase
    return nx;
  endfunction

  function automatic logic is_shift(input tap_st_e st);
    return (st == TS_SHF_IR) || (st == TS_SHF_DR);
  endfunction

endpackage

// File: rtl/mts_tap_fsm.sv
module mts_tap_fsm
  import mts_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e state,
  output logic    upd_ir_ev,
  output logic    tlr_ev
);

  tap_st_e st_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st_q <= TS_RESET;
    else         st_q <= tap_next(st_q, tms);
  end

  assign state     = st_q;
  assign upd_ir_ev = (st_q == TS_UPD_IR);
  assign tlr_ev    = (st_q == TS_RESET);

endmodule

// File: rtl/mts_addr_match.sv
module mts_addr_match
  import mts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] slot,
  input  logic [GRP_W-1:0]  grp,
  output sel_kind_e         kind
);

  localparam int N_GRP = 1 << GRP_W;
  localparam logic [ADDR_W-1:0] BCAST_CODE = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MC_BASE    = BCAST_CODE - ADDR_W'(N_GRP);

  function automatic sel_kind_e decode(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] s,
                                       input logic [GRP_W-1:0]  g);
    if (a == BCAST_CODE)
      return SK_BCAST;
    if (a >= MC_BASE)
      return (a == MC_BASE + ADDR_W'(g)) ? SK_MCAST : SK_NONE;
    if (a == s)
      return SK_UNIQUE;
    return SK_NONE;
  endfunction

  assign kind = decode(addr, slot, grp);

endmodule

// File: rtl/mts_select_fsm.sv
module mts_select_fsm
  import mts_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  logic      upd_ir_ev,
  input  logic      tlr_ev,
  input  sel_kind_e match_kind,
  output sel_kind_e sel
);

  sel_kind_e sel_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        sel_q <= SK_NONE;
    else if (tlr_ev)    sel_q <= SK_NONE;
    else if (upd_ir_ev) sel_q <= match_kind;
  end

  assign sel = sel_q;

endmodule

// File: rtl/mts_scan_path.sv
module mts_scan_path
  import mts_pkg::*;
#(
  parameter int          IR_W       = 8,
  parameter int          ADDR_W     = 6,
  parameter bit          HAS_IDCODE = 1'b1,
  parameter logic [31:0] IDCODE     = 32'h4D2A_6C35
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_st_e           state,
  input  logic              drive_ok,
  output logic [ADDR_W-1:0] ir_addr,
  output logic              tdo,
  output logic              tdo_oe
);

  localparam int DR_W = HAS_IDCODE ? 32 : 1;
  localparam logic [IR_W-1:0] IR_CAPT = IR_W'(1);

  logic [IR_W-1:0] ir_sh;
  logic [DR_W-1:0] dr_sh;
  logic [DR_W-1:0] dr_capt;
  logic            tdo_q, oe_q;

  generate
    if (HAS_IDCODE) begin : g_idcode
      assign dr_capt = IDCODE[DR_W-1:0];
    end else begin : g_bypass
      assign dr_capt = '0;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPT;
      dr_sh <= '0;
    end else begin
      case (state)
        TS_CAP_IR: ir_sh <= IR_CAPT;
        TS_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        TS_CAP_DR: dr_sh <= dr_capt;
        TS_SHF_DR: begin
          if (DR_W > 1) dr_sh <= {tdi, dr_sh[DR_W-1:1]};
          else          dr_sh <= DR_W'(tdi);
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= (state == TS_SHF_IR) ? ir_sh[0] : dr_sh[0];
      oe_q  <= drive_ok && is_shift(state);
    end
  end

  assign ir_addr = ir_sh[ADDR_W-1:0];
  assign tdo     = tdo_q;
  assign tdo_oe  = oe_q;

endmodule

// File: rtl/mts_top.sv
module mts_top
  import mts_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          GRP_W      = 2,
  parameter int          IR_W       = 8,
  parameter bit          HAS_IDCODE = 1'b1,
  parameter logic [31:0] IDCODE     = 32'h4D2A_6C35
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic [GRP_W-1:0]  mcast_grp,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [1:0]        sel_kind
);

  tap_st_e           tap_state;
  logic              upd_ir_ev;
  logic              tlr_ev;
  logic [ADDR_W-1:0] ir_addr;
  sel_kind_e         match_kind;
  sel_kind_e         sel_q;
  logic              unique_sel;

  mts_tap_fsm u_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .state(tap_state), .upd_ir_ev(upd_ir_ev), .tlr_ev(tlr_ev)
  );

  mts_addr_match #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_match (
    .addr(ir_addr), .slot(slot_id), .grp(mcast_grp), .kind(match_kind)
  );

  mts_select_fsm u_sel (
    .tck(tck), .trst_n(trst_n), .upd_ir_ev(upd_ir_ev), .tlr_ev(tlr_ev),
    .match_kind(match_kind), .sel(sel_q)
  );

  assign unique_sel = (sel_q == SK_UNIQUE);

  mts_scan_path #(.IR_W(IR_W), .ADDR_W(ADDR_W), .HAS_IDCODE(HAS_IDCODE),
                  .IDCODE(IDCODE)) u_path (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state),
    .drive_ok(unique_sel), .ir_addr(ir_addr), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  assign sel_kind = sel_q;

endmodule

// File: rtl/mts_checker.sv
module mts_checker
  import mts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              tck,
  input logic              trst_n,
  input tap_st_e           tap_state,
  input logic              upd_ev,
  input logic              tlr_ev,
  input logic [ADDR_W-1:0] ir_addr,
  input sel_kind_e         sel,
  input logic              tdo_oe
);

  assert_shared_quiet_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (sel != SK_UNIQUE) |-> !tdo_oe);

  assert_oe_in_shift_R7: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> is_shift(tap_state));

  assert_sel_moves_on_update_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (sel != $past(sel)) |-> ($past(upd_ev) || $past(tlr_ev)));

  assert_bcast_code_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_ev && !tlr_ev && (ir_addr == {ADDR_W{1'b1}})) |=> (sel == SK_BCAST));

  assert_tlr_clears_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tlr_ev |=> (sel == SK_NONE));

endmodule

bind mts_top mts_checker #(.ADDR_W(ADDR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .upd_ev(upd_ir_ev),
  .tlr_ev(tlr_ev), .ir_addr(ir_addr), .sel(sel_q), .tdo_oe(tdo_oe)
);

// File: tb/test_mts_top.sv
module test_mts_top;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [5:0] slot_id = 6'd5;
  logic [1:0] mcast_grp = 2'd1;
  logic       tdo;
  logic       tdo_oe;
  logic [1:0] sel_kind;

  int checks = 0;
  int errors = 0;
  logic smp_tdo, smp_oe;
  logic [1:0] exp_sel = 2'd0;
  logic [7:0]  ir_out;
  logic [31:0] dr_out;
  logic oe_shift_all, oe_shift_any, oe_other_any;

  localparam logic [31:0] ID_VAL = 32'h4D2A_6C35;

  mts_top i_mts_top (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .slot_id(slot_id), .mcast_grp(mcast_grp),
    .tdo(tdo), .tdo_oe(tdo_oe), .sel_kind(sel_kind)
  );

  always #5 tck = ~tck;

  initial begin
    repeat (200000) @(posedge tck);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // bench model of address decode, written from the requirement text
  function automatic logic [1:0] model_kind(input logic [5:0] a,
                                            input logic [5:0] s,
                                            input logic [1:0] g);
    int ai;
    ai = int'(a);
    if (ai == 63) return 2'd2;
    if (ai >= 59 && ai <= 62) return ((ai - 59) == int'(g)) ? 2'd3 : 2'd0;
    if (ai == int'(s) && int'(s) <= 58) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, input logic in_shift);
    @(negedge tck);
    #1;
    smp_tdo = tdo;
    smp_oe  = tdo_oe;
    if (in_shift) begin
      oe_shift_all = oe_shift_all & smp_oe;
      oe_shift_any = oe_shift_any | smp_oe;
    end else begin
      oe_other_any = oe_other_any | smp_oe;
    end
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic clr_oe();
    oe_shift_all = 1'b1;
    oe_shift_any = 1'b0;
    oe_other_any = 1'b0;
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [7:0] v);
    clr_oe();
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, v[i], 1'b1);
      ir_out[i] = smp_tdo;
    end
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic scan_dr();
    clr_oe();
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      step(i == 31, 1'b0, 1'b1);
      dr_out[i] = smp_tdo;
    end
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  // scan an address and judge kind and driver behaviour of the shift
  task automatic addr_scan(input string req, input logic [5:0] a);
    logic [1:0] prior;
    prior = exp_sel;
    scan_ir({2'b00, a});
    exp_sel = model_kind(a, slot_id, mcast_grp);
    chk(req, 32'(sel_kind), 32'(exp_sel));
    if (prior == 2'd1) begin
      chk("R7 oe high through shift", 32'(oe_shift_all), 32'd1);
      chk("R7 oe low outside shift", 32'(oe_other_any), 32'd0);
      chk("R8 IR capture on tdo", 32'(ir_out), 32'h01);
    end else begin
      chk("R6 oe stays low", 32'(oe_shift_any | oe_other_any), 32'd0);
    end
  endtask

  initial begin
    // R1 reset
    #23;
    chk("R1 kind in reset", 32'(sel_kind), 32'd0);
    chk("R1 oe in reset", 32'(tdo_oe), 32'd0);
    @(negedge tck); trst_n = 1'b1;
    to_idle();
    chk("R1 kind after reset", 32'(sel_kind), 32'd0);
    chk("R1 oe after reset", 32'(tdo_oe), 32'd0);

    // R2 unique, then R7/R8 on the next IR scan, R9 on DR
    addr_scan("R2 unique select", 6'd5);
    addr_scan("R2 unique reselect", 6'd5);
    scan_dr();
    chk("R9 idcode on tdo", dr_out, ID_VAL);
    chk("R7 oe through DR shift", 32'(oe_shift_all), 32'd1);

    // R3 mismatch while selected and while waiting
    addr_scan("R3 deselect on mismatch", 6'd7);
    addr_scan("R3 mismatch from wait", 6'd9);

    // R4 broadcast; R6 no drive while shared
    slot_id = 6'd17;
    addr_scan("R4 broadcast", 6'h3F);
    addr_scan("R4 broadcast again", 6'h3F);
    scan_dr();
    chk("R6 oe low in DR under broadcast", 32'(oe_shift_any | oe_other_any), 32'd0);

    // R5 multicast member then non-member
    addr_scan("R5 multicast member", 6'h3C);
    addr_scan("R5 multicast other group", 6'h3D);
    chk("R5 non-member kind none", 32'(sel_kind), 32'd0);

    // unique then straight to broadcast
    addr_scan("R2 unique before switch", 6'd17);
    addr_scan("R4 switch unique to broadcast", 6'h3F);
    addr_scan("R6 shift after switch", 6'h3F);

    // R10 TLR by TMS
    addr_scan("R2 unique before TLR", 6'd17);
    to_idle();
    exp_sel = 2'd0;
    chk("R10 TLR deselects", 32'(sel_kind), 32'd0);

    // R11 asynchronous TRST
    addr_scan("R2 unique before TRST", 6'd17);
    @(negedge tck); #2; trst_n = 1'b0; #1;
    chk("R11 TRST deselects at once", 32'(sel_kind), 32'd0);
    @(negedge tck); trst_n = 1'b1;
    exp_sel = 2'd0;
    to_idle();

    // R12 reserved slot value
    slot_id = 6'h3D; mcast_grp = 2'd0;
    addr_scan("R12 reserved slot not unique", 6'h3D);
    chk("R12 kind none", 32'(sel_kind), 32'd0);
    addr_scan("R5 group 0 member", 6'h3B);

    // constrained random addresses
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 80; n++) begin
      logic [5:0] a;
      int pick;
      slot_id   = 6'($urandom_range(0, 63));
      mcast_grp = 2'($urandom_range(0, 3));
      pick = $urandom_range(0, 2);
      if (pick == 0)      a = slot_id;
      else if (pick == 1) a = 6'($urandom_range(59, 63));
      else                a = 6'($urandom_range(0, 63));
      addr_scan("R3 random address decode", a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule